// File: doc/BRIEF.md
# Triggered Acquisition Sequencer

This block decides which samples of a probed data bus reach the circular capture memory of an on-chip logic analyzer. It runs in the acquisition clock domain. Every action waits for a clock-enable, so a slower sample rate can be chosen with a strobe, without a second clock. A capture cycle first gathers pre-trigger history. It then waits, armed, for a trigger edge or a manual start. After that it writes the post-trigger samples and then either rearms itself or stops.

The window is set by two values that are loaded at the start of each cycle. A depth `D` asks for `D+1` samples. A signed drift `F` gives the trigger's place counted from the first sample of the window. A positive drift puts the trigger inside the window, or past its end. A negative drift starts the window after the trigger. The memory address of the trigger sample is held on a port, so a readout can align its view to it. The memory is an inferred simple dual-port array with a registered read port.

Top module: `acq_sequencer`

## Requirements
- R1: Synchronous active-high reset clears `wr_en`, `wr_addr` and `trig_addr`. It loads the default depth and drift. With `START_ACTIVE`=1 the state becomes Fill, or Ready if the default prefill is zero; otherwise it becomes Stop. The `seq_state` code is 00 Fill, 01 Ready, 10 Run, 11 Stop.
- R2: While `acq_ena` is low, the state, the address and the trigger address hold, and `wr_en` is 0 one cycle later. Requests and trigger edges on such cycles have no effect.
- R3: Each enabled cycle in Fill, Ready or Run writes `sample_in` to the current address. The address then steps by one, modulo `2**AW`. `wr_en` and `wr_addr` show that write one cycle later. Stop writes nothing.
- R4: Fill writes `max(F,0)` samples, capped at `2**AW-1`, and then moves to Ready. When that count is zero, a cycle starts directly in Ready.
- R5: A trigger is an enabled cycle in which the trigger input is 1 and was 0 on the previous enabled cycle. It acts only in Ready. A level held high from an earlier state does not fire.
- R6: A request in Ready starts the capture exactly as a trigger would.
- R7: On a trigger or a manual start, `trig_addr` takes the address of the sample written in that cycle.
- R8: After the trigger sample, Run writes `max(D-F,0)` more samples and then ends the cycle.
- R9: At the end of a cycle, with `cfg_single`=0 a new cycle starts at once with freshly loaded depth and drift. With `cfg_single`=1 the state goes to Stop.
- R10: A request in Stop starts a new cycle with freshly loaded settings. A request in Fill or Run aborts to Stop.
- R11: A sample written at an address reads back on `rd_data` one cycle after `rd_addr` selects that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_ena | input | 1 | Acquisition clock-enable |
| sample_in | input | DW | Probed data |
| trig_in | input | 1 | Trigger line |
| run_req | input | 1 | Start/stop request, acts on enabled cycles |
| cfg_single | input | 1 | 1 = single capture, 0 = rearm automatically |
| cfg_depth | input | AW | Window length minus one |
| cfg_drift | input | OW | Signed trigger offset from window start |
| rd_addr | input | AW | Readout address |
| rd_data | output | DW | Readout data, one cycle latency |
| wr_en | output | 1 | Write performed (registered) |
| wr_addr | output | AW | Address of that write (registered) |
| seq_state | output | 2 | State code |
| trig_addr | output | AW | Address of the trigger sample |

## Verification
A wrong internal count shows as a state change on `seq_state` that comes one enabled cycle too early or too late. It appears at the first Fill-to-Ready or Run-to-end boundary after the fault. A stuck or skipped pointer shows on `wr_addr` one cycle after the faulty write. The same fault shows on `trig_addr` at the next trigger. A lost or doubled edge shows as Ready held too long, or left at once. A reference model runs in step with the design and compares all four status outputs on every cycle. The memory is read back after a single capture ends.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [1:0] {
    ST_FILL  = 2'b00,
    ST_READY = 2'b01,
    ST_RUN   = 2'b10,
    ST_STOP  = 2'b11
  } acq_state_e;
endpackage

// File: rtl/acq_trig_detect.sv
module acq_trig_detect #(
  parameter bit REG_IN = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ena,
  input  logic trig_in,
  output logic trig_edge
);
  logic trig_s;
  logic trig_prev;

  generate
    if (REG_IN) begin : g_reg
      logic trig_q;
      always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
      end
      assign trig_s = trig_q;
    end else begin : g_direct
      assign trig_s = trig_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      trig_prev <= 1'b0;
    else if (ena) trig_prev <= trig_s;
  end

  assign trig_edge = ena & trig_s & ~trig_prev;

  // edge only on an enabled cycle (R5)
  p_edge_needs_ena_r5: assert property (@(posedge clk) disable iff (rst)
    trig_edge |-> ena);
endmodule

// File: rtl/acq_ram.sv
module acq_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_seq_pkg::*;
#(
  parameter int AW           = 6,
  parameter int OW           = 16,
  parameter int DEF_DEPTH    = 7,
  parameter int DEF_DRIFT    = 3,
  parameter bit START_ACTIVE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ena,
  input  logic                 trig_edge,
  input  logic                 req,
  input  logic                 cfg_single,
  input  logic [AW-1:0]        cfg_depth,
  input  logic signed [OW-1:0] cfg_drift,
  output acq_state_e           state_o,
  output logic [AW-1:0]        ptr_o,
  output logic                 we_o,
  output logic [AW-1:0]        tpos_o
);
  localparam int CW      = OW + 2;
  localparam int RAM_LEN = 1 << AW;
  localparam logic [AW-1:0]        DEPTH0 = AW'(DEF_DEPTH);
  localparam logic signed [OW-1:0] DRIFT0 = OW'(DEF_DRIFT);

  function automatic logic [CW-1:0] f_fill(input logic signed [OW-1:0] dr);
    logic signed [CW-1:0] d;
    d = {{(CW-OW){dr[OW-1]}}, dr};
    if (d <= 0)                 return '0;
    else if (d > RAM_LEN - 1)   return CW'(RAM_LEN - 1);
    else                        return $unsigned(d);
  endfunction

  function automatic logic [CW-1:0] f_run(input logic [AW-1:0] dp,
                                          input logic signed [OW-1:0] dr);
    logic signed [CW-1:0] d;
    logic signed [CW-1:0] diff;
    d    = {{(CW-OW){dr[OW-1]}}, dr};
    diff = $signed({{(CW-AW){1'b0}}, dp}) - d;
    if (diff < 0) return '0;
    else          return $unsigned(diff);
  endfunction

  acq_state_e    state, nxt_state;
  logic [CW-1:0] cnt, nxt_cnt;
  logic [CW-1:0] fill_n, run_n;
  logic [AW-1:0] ptr, tpos;
  logic          load_cfg, latch_tpos;
  logic [CW-1:0] new_fill, new_run;

  assign new_fill = f_fill(cfg_drift);
  assign new_run  = f_run(cfg_depth, cfg_drift);
  assign we_o     = ena && (state != ST_STOP);

  // next-state decision for one enabled cycle
  always_comb begin
    nxt_state  = state;
    nxt_cnt    = cnt;
    load_cfg   = 1'b0;
    latch_tpos = 1'b0;
    unique case (state)
      ST_FILL: begin
        if (req) nxt_state = ST_STOP;
        else if (cnt + 1'b1 == fill_n) begin
          nxt_state = ST_READY;
          nxt_cnt   = '0;
        end else nxt_cnt = cnt + 1'b1;
      end
      ST_READY: begin
        if (req || trig_edge) begin
          latch_tpos = 1'b1;
          nxt_cnt    = '0;
          if (run_n == '0) begin
            if (cfg_single) nxt_state = ST_STOP;
            else            load_cfg  = 1'b1;
          end else nxt_state = ST_RUN;
        end
      end
      ST_RUN: begin
        if (req) nxt_state = ST_STOP;
        else if (cnt + 1'b1 == run_n) begin
          if (cfg_single) nxt_state = ST_STOP;
          else            load_cfg  = 1'b1;
        end else nxt_cnt = cnt + 1'b1;
      end
      default: begin
        if (req) load_cfg = 1'b1;
      end
    endcase
    if (load_cfg) begin
      nxt_state = (new_fill == '0) ? ST_READY : ST_FILL;
      nxt_cnt   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= START_ACTIVE ? ((f_fill(DRIFT0) == '0) ? ST_READY : ST_FILL)
                             : ST_STOP;
      cnt    <= '0;
      fill_n <= f_fill(DRIFT0);
      run_n  <= f_run(DEPTH0, DRIFT0);
      ptr    <= '0;
      tpos   <= '0;
    end else if (ena) begin
      state <= nxt_state;
      cnt   <= nxt_cnt;
      if (we_o)       ptr    <= ptr + 1'b1;
      if (latch_tpos) tpos   <= ptr;
      if (load_cfg) begin
        fill_n <= new_fill;
        run_n  <= new_run;
      end
    end
  end

  assign state_o = state;
  assign ptr_o   = ptr;
  assign tpos_o  = tpos;

  // R2: nothing moves on a disabled cycle
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ena |=> $stable(state) && $stable(ptr) && $stable(tpos));
  // R3: pointer steps by one on each write
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    we_o |=> ptr == $past(ptr) + 1'b1);
  // R3: Stop writes nothing
  p_stop_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP) |-> !we_o);
  // R4: prefill counter stays below its target
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL) |-> cnt < fill_n);
  // R7: trigger address changes only when leaving Ready
  p_tpos_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (state != ST_READY) |=> $stable(tpos));
  // R8: post-trigger counter stays below its target
  p_run_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> cnt < run_n);
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int AW           = 6,
  parameter int DW           = 8,
  parameter int OW           = 16,
  parameter int DEF_DEPTH    = 7,
  parameter int DEF_DRIFT    = 3,
  parameter bit START_ACTIVE = 1'b1,
  parameter bit TRIG_REG     = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acq_ena,
  input  logic [DW-1:0]        sample_in,
  input  logic                 trig_in,
  input  logic                 run_req,
  input  logic                 cfg_single,
  input  logic [AW-1:0]        cfg_depth,
  input  logic signed [OW-1:0] cfg_drift,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic [1:0]           seq_state,
  output logic [AW-1:0]        trig_addr
);
  import acq_seq_pkg::*;

  logic          trig_edge;
  logic          we_now;
  logic [AW-1:0] ptr;
  acq_state_e    st;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  acq_trig_detect #(.REG_IN(TRIG_REG)) u_trig (
    .clk(clk), .rst(rst), .ena(acq_ena), .trig_in(trig_in), .trig_edge(trig_edge)
  );

  acq_ctrl #(
    .AW(AW), .OW(OW), .DEF_DEPTH(DEF_DEPTH), .DEF_DRIFT(DEF_DRIFT),
    .START_ACTIVE(START_ACTIVE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .ena(acq_ena), .trig_edge(trig_edge), .req(run_req),
    .cfg_single(cfg_single), .cfg_depth(cfg_depth), .cfg_drift(cfg_drift),
    .state_o(st), .ptr_o(ptr), .we_o(we_now), .tpos_o(trig_addr)
  );

  // write staging: outputs and memory port come from registers
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      we_q   <= we_now;
      addr_q <= ptr;
    end
    data_q <= sample_in;
  end

  acq_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(we_q), .waddr(addr_q), .wdata(data_q),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign wr_en     = we_q;
  assign wr_addr   = addr_q;
  assign seq_state = st;

  // R2: no write reported after a disabled cycle
  p_wen_needs_ena_r2: assert property (@(posedge clk) disable iff (rst)
    !acq_ena |=> !wr_en);
endmodule

// File: tb/acq_sequencer_tb.sv
module acq_sequencer_tb_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int OW = 16;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acq_ena = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic trig_in = 1'b0;
  logic run_req = 1'b0;
  logic cfg_single = 1'b1;
  logic [AW-1:0] cfg_depth = 6'd7;
  logic signed [OW-1:0] cfg_drift = 16'sd3;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [1:0] seq_state;
  logic [AW-1:0] trig_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  acq_sequencer #(.AW(AW), .DW(DW), .OW(OW), .DEF_DEPTH(7), .DEF_DRIFT(3),
                  .START_ACTIVE(1'b1), .TRIG_REG(1'b0)) dut_i (
    .clk(clk), .rst(rst), .acq_ena(acq_ena), .sample_in(sample_in),
    .trig_in(trig_in), .run_req(run_req), .cfg_single(cfg_single),
    .cfg_depth(cfg_depth), .cfg_drift(cfg_drift), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .seq_state(seq_state), .trig_addr(trig_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model, written from the requirements
  int m_state, m_cnt, m_fill, m_run, m_ptr, m_tpos, m_we, m_waddr;
  bit m_prev;
  int mem_m [N];
  bit wrote [N];

  function automatic int fill_of(input int dr);
    if (dr <= 0) return 0;
    if (dr > N - 1) return N - 1;
    return dr;
  endfunction
  function automatic int run_of(input int dp, input int dr);
    return (dp - dr < 0) ? 0 : dp - dr;
  endfunction

  task automatic m_load();
    m_fill  = fill_of(int'(cfg_drift));
    m_run   = run_of(int'(cfg_depth), int'(cfg_drift));
    m_state = (m_fill == 0) ? 1 : 0;
    m_cnt   = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_fill = fill_of(3); m_run = run_of(7, 3);
      m_state = (m_fill == 0) ? 1 : 0;
      m_cnt = 0; m_ptr = 0; m_tpos = 0; m_we = 0; m_waddr = 0; m_prev = 0;
    end else begin
      m_we = (acq_ena && m_state != 3) ? 1 : 0;
      m_waddr = m_ptr;
      if (acq_ena) begin
        bit edg;
        int p;
        edg = trig_in && !m_prev;
        m_prev = trig_in;
        p = m_ptr;
        if (m_state != 3) begin
          mem_m[p] = int'(sample_in); wrote[p] = 1'b1;
          m_ptr = (p + 1) % N;
        end
        case (m_state)
          0: if (run_req) m_state = 3;
             else if (m_cnt + 1 == m_fill) begin m_state = 1; m_cnt = 0; end
             else m_cnt++;
          1: if (run_req || edg) begin
               m_tpos = p; m_cnt = 0;
               if (m_run == 0) begin
                 if (cfg_single) m_state = 3; else m_load();
               end else m_state = 2;
             end
          2: if (run_req) m_state = 3;
             else if (m_cnt + 1 == m_run) begin
               if (cfg_single) m_state = 3; else m_load();
             end else m_cnt++;
          default: if (run_req) m_load();
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R9 state", int'(seq_state), m_state);
      chk("R2 wr_en", int'(wr_en), m_we);
      chk("R3 wr_addr", int'(wr_addr), m_waddr);
      chk("R7 trig_addr", int'(trig_addr), m_tpos);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin
      sample_in = DW'($urandom);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic ram_check();
    for (int i = 0; i < N; i++) begin
      rd_addr = AW'(i);
      tick();
      if (wrote[i]) chk("R11 readback", int'(rd_data), mem_m[i]);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    tick(2);
    chk("R1 reset state", int'(seq_state), 0);
    chk("R1 reset wr_en", int'(wr_en), 0);
    chk("R1 reset wr_addr", int'(wr_addr), 0);
    chk("R1 reset trig_addr", int'(trig_addr), 0);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R2: disabled cycles, request ignored
    run_req = 1'b1;
    tick(4);
    chk("R2 hold state", int'(seq_state), 0);
    chk("R2 hold addr", int'(wr_addr), 0);
    chk("R2 no write", int'(wr_en), 0);
    run_req = 1'b0;

    // R4 prefill of 3, trigger held high through it (R5)
    acq_ena = 1'b1; trig_in = 1'b1;
    tick(2);
    chk("R4 still filling", int'(seq_state), 0);
    tick();
    chk("R4 ready after 3", int'(seq_state), 1);
    tick(3);
    chk("R5 level no fire", int'(seq_state), 1);
    trig_in = 1'b0; tick();
    trig_in = 1'b1; tick();
    chk("R5 edge fires", int'(seq_state), 2);
    chk("R7 trigger address", int'(trig_addr), 7);
    chk("R3 write address", int'(wr_addr), 7);
    trig_in = 1'b0;
    tick(3);
    chk("R8 still running", int'(seq_state), 2);
    tick();
    chk("R9 single stops", int'(seq_state), 3);
    tick();
    chk("R3 no write in stop", int'(wr_en), 0);

    // R10 restart with negative drift -> straight to Ready
    cfg_depth = 6'd3; cfg_drift = -16'sd2;
    run_req = 1'b1; tick(); run_req = 1'b0;
    chk("R10 restart", int'(seq_state), 1);
    tick();
    run_req = 1'b1; tick(); run_req = 1'b0;
    chk("R6 manual start", int'(seq_state), 2);
    chk("R6 trig_addr at start", int'(trig_addr), int'(wr_addr));
    tick(2);
    run_req = 1'b1; tick(); run_req = 1'b0;
    chk("R10 abort", int'(seq_state), 3);

    // R9 normal mode rearm with zero depth and drift
    cfg_single = 1'b0; cfg_depth = 6'd0; cfg_drift = 16'sd0;
    run_req = 1'b1; tick(); run_req = 1'b0;
    trig_in = 1'b1; tick();
    chk("R9 rearm", int'(seq_state), 1);
    chk("R7 trig on rearm", int'(trig_addr), int'(wr_addr));
    tick();
    chk("R5 no refire", int'(seq_state), 1);
    trig_in = 1'b0;
    cfg_single = 1'b1;
    run_req = 1'b1; tick(); run_req = 1'b0;
    chk("R9 single end", int'(seq_state), 3);
    tick(2);
    ram_check();

    // constrained random phase
    for (int k = 0; k < 4000; k++) begin
      acq_ena = ($urandom % 4) != 0;
      if ($urandom % 8 == 0) trig_in = ~trig_in;
      run_req = ($urandom % 48) == 0;
      if ($urandom % 16 == 0) begin
        cfg_depth  = AW'($urandom % N);
        cfg_drift  = OW'(int'($urandom % 100) - 30);
        cfg_single = $urandom % 2;
      end
      tick();
    end
    acq_ena = 1'b1; trig_in = 1'b0; run_req = 1'b0; cfg_single = 1'b1;
    for (int k = 0; k < 600 && seq_state != 2'b11; k++) begin
      run_req = (seq_state == 2'b01);
      tick();
    end
    run_req = 1'b0;
    chk("R9 final stop", int'(seq_state), 3);
    tick(2);
    ram_check();
    summary();
  end
endmodule